// File: doc/BRIEF.md
# Busy-Response Completion Monitor

This block sits next to the interrupt status logic of an SD host controller. It corrects completion signalling for commands whose response is followed by a busy indication on the DAT0 line. Some controllers raise their completion interrupt while the card still holds the line low. This monitor is armed when the host issues such a command. It holds back the early interrupt and watches the present-state busy bits. It then reports the proper completion itself: a synthesized transfer-complete, or a synthesized data-timeout if the line stays busy too long.

The host reads `mergedStatus` in place of the raw interrupt status. The synthesized bits are ORed into that value and are cleared by writing 1s. A status write is also passed on to the controller through `hwClear`/`hwClearMask`. The same strobe removes a held-back interrupt from the hardware status while the monitor waits for the line. Busy is rechecked on a millisecond tick, which comes from a prescaler on the system clock. The deadline is a fixed number of ticks.

Top module: `busy_done_mon`

## Requirements
- R1: In the cycle after `cmdIssue` with `cmdHasData`=0 and `cmdRespType`=2'b11 (short response with busy), the monitor is armed in no-data mode; its trigger is the command-response bit (`hwStatus[RESP_BIT]`, default bit 0). Any other no-data response type does not arm it.
- R2: In the cycle after `cmdIssue` with `cmdHasData`=1, `xferAutoStop`=1 and `xferMulti`=1, the monitor is armed in auto-stop mode; its trigger is the transfer-complete bit (`hwStatus[DE_BIT]`, default bit 1). A data command lacking either transfer-mode bit does not arm it.
- R3: The line counts as busy when `lineActive` or `dataInhibit` is 1; either bit alone is enough.
- R4: If the trigger appears while the line is free, the trigger bit is masked from `mergedStatus` in that cycle. `hwClear` stays low, and one cycle later the synthesized transfer-complete bit is set. In no-data mode the synthesized command-response bit is set as well.
- R5: If the trigger appears while the line is busy, `hwClear` is high in that cycle with `hwClearMask` equal to only the trigger bit. The trigger stays hidden from `mergedStatus` while the monitor waits.
- R6: While waiting, busy is rechecked once every `TICK_DIV` cycles, counted from the trigger cycle. At the first recheck that finds the line free, transfer-complete is synthesized (plus command-response in no-data mode), visible one cycle after that recheck. In auto-stop mode no command-response bit is synthesized.
- R7: If the line is still busy at recheck number `TIMEOUT_MS`, only the synthesized data-timeout bit (`DTO_BIT`, default bit 20) is set. With the trigger in cycle T, it is visible in cycle T + `TIMEOUT_MS`*`TICK_DIV` + 1.
- R8: `mergedStatus` is the raw status ORed with the synthesized bits. A raw bit is masked only while it is the armed trigger. A cycle with `statusWrite` clears the synthesized bits written as 1, from the next cycle. In that same cycle it drives `hwClear`=1 with `statusWrData` included in `hwClearMask`; reset leaves the outputs at 0.
- R9: After completion by release or timeout, the monitor is disarmed: a later trigger-type raw bit passes to `mergedStatus` unmasked and causes no `hwClear`.
- R10: `irq` is 1 when `mergedStatus` AND the enable set is non-zero. The enable set is `sigEnable`, plus the command-response bit from a no-data arm until a status write clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdIssue | input | 1 | One-cycle strobe: command register written |
| cmdHasData | input | 1 | Issued command transfers data |
| cmdRespType | input | 2 | Response type of the issued command, 2'b11 = short with busy |
| xferAutoStop | input | 1 | Transfer mode: automatic stop command enabled |
| xferMulti | input | 1 | Transfer mode: multi-block transfer |
| hwStatus | input | W | Raw controller interrupt status |
| sigEnable | input | W | Interrupt signal enable mask |
| lineActive | input | 1 | Present state: data line active |
| dataInhibit | input | 1 | Present state: data command inhibit |
| statusWrite | input | 1 | Host writes the interrupt status this cycle |
| statusWrData | input | W | Write-1-to-clear data of that write |
| mergedStatus | output | W | Status presented to the host |
| irq | output | 1 | Interrupt request |
| hwClear | output | 1 | Strobe to clear bits of the raw status |
| hwClearMask | output | W | Bits to clear in the raw status |

## Verification
Masking of the trigger and the deferral strobe (`hwClear` with the trigger bit) are combinational and are sampled in the trigger cycle itself. Synthesized bits, and clears made by a status write, are registered and checked one cycle after the deciding cycle. For waits, the bench counts cycles from the trigger cycle and records the first cycle in which the synthesized bit appears. That cycle must be one past the recheck tick: the first tick after the release, or tick `TIMEOUT_MS` for a timeout. All signals are sampled on the falling edge after inputs settle.

// File: rtl/busy_done_pkg.sv
`timescale 1ns/1ps
package busy_done_pkg;
  localparam logic [1:0] RESP_SHORT_BUSY = 2'b11;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_NODATA = 2'd1,
    MODE_AC12   = 2'd2
  } arm_mode_t;

  typedef struct packed {
    logic holdResp;     // armed with command-response as trigger
    logic holdDe;       // armed with transfer-complete as trigger
    logic deferClr;     // trigger seen while busy: clear it in hardware
    logic startWait;    // restart tick prescaler and ms counter
    logic doneRelease;  // line freed: synthesize transfer-complete
    logic addResp;      // also synthesize command-response
    logic doneTimeout;  // deadline reached: synthesize data-timeout
    logic forceSet;     // force command-response enable
  } ctrl_strobe_t;
endpackage

// File: rtl/busy_done_ctrl.sv
`timescale 1ns/1ps
module busy_done_ctrl
  import busy_done_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdIssue,
  input  logic         cmdHasData,
  input  logic [1:0]   cmdRespType,
  input  logic         xferAutoStop,
  input  logic         xferMulti,
  input  logic         hwRespBit,
  input  logic         hwDeBit,
  input  logic         lineActive,
  input  logic         dataInhibit,
  input  logic         tick,
  input  logic         timeoutHit,
  output ctrl_strobe_t strobe
);
  arm_mode_t mode;
  logic      waiting;
  logic      busy, trig, armNodata, armAc12, finishNow, finishLate, timedOut;

  always_comb begin
    busy       = lineActive | dataInhibit;
    trig       = !waiting &&
                 (((mode == MODE_NODATA) && hwRespBit) ||
                  ((mode == MODE_AC12) && hwDeBit));
    finishNow  = trig && !busy;
    finishLate = waiting && tick && !busy;
    timedOut   = waiting && tick && busy && timeoutHit;
    armNodata  = cmdIssue && !waiting && !cmdHasData &&
                 (cmdRespType == RESP_SHORT_BUSY);
    armAc12    = cmdIssue && !waiting && cmdHasData && xferAutoStop && xferMulti;

    strobe             = '0;
    strobe.holdResp    = (mode == MODE_NODATA);
    strobe.holdDe      = (mode == MODE_AC12);
    strobe.deferClr    = trig && busy;
    strobe.startWait   = trig && busy;
    strobe.doneRelease = finishNow || finishLate;
    strobe.addResp     = (finishNow || finishLate) && (mode == MODE_NODATA);
    strobe.doneTimeout = timedOut;
    strobe.forceSet    = armNodata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= MODE_NONE;
      waiting <= 1'b0;
    end else begin
      if (finishNow || finishLate || timedOut) begin
        mode    <= MODE_NONE;
        waiting <= 1'b0;
      end else if (trig && busy) begin
        waiting <= 1'b1;
      end
      if (armNodata)    mode <= MODE_NODATA;
      else if (armAc12) mode <= MODE_AC12;
    end
  end
endmodule

// File: rtl/busy_done_dp.sv
`timescale 1ns/1ps
module busy_done_dp
  import busy_done_pkg::*;
#(
  parameter int W          = 32,
  parameter int TICK_DIV   = 125000,
  parameter int TIMEOUT_MS = 250,
  parameter int RESP_BIT   = 0,
  parameter int DE_BIT     = 1,
  parameter int DTO_BIT    = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  input  logic [W-1:0] hwStatus,
  input  logic [W-1:0] sigEnable,
  input  logic         statusWrite,
  input  logic [W-1:0] statusWrData,
  output logic         tick,
  output logic         timeoutHit,
  output logic [W-1:0] mergedStatus,
  output logic         irq,
  output logic         hwClear,
  output logic [W-1:0] hwClearMask
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MW = $clog2(TIMEOUT_MS + 1);
  localparam logic [W-1:0] RESP_MASK = W'(1) << RESP_BIT;
  localparam logic [W-1:0] DE_MASK   = W'(1) << DE_BIT;
  localparam logic [W-1:0] DTO_MASK  = W'(1) << DTO_BIT;

  logic [PW-1:0] preCnt;
  logic [MW-1:0] msCnt;
  logic [W-1:0]  synth, setVec, clrVec, holdVec, enVec;
  logic          respForce;

  assign tick       = (preCnt == PW'(TICK_DIV - 1));
  assign timeoutHit = (msCnt == MW'(TIMEOUT_MS - 1));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.startWait) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) msCnt <= msCnt + 1'b1;
    end
  end

  always_comb begin
    setVec = '0;
    if (strobe.doneRelease) setVec = setVec | DE_MASK;
    if (strobe.addResp)     setVec = setVec | RESP_MASK;
    if (strobe.doneTimeout) setVec = setVec | DTO_MASK;
    clrVec  = statusWrite ? statusWrData : '0;
    holdVec = (strobe.holdResp ? RESP_MASK : '0) | (strobe.holdDe ? DE_MASK : '0);
    enVec   = sigEnable | (respForce ? RESP_MASK : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      synth     <= '0;
      respForce <= 1'b0;
    end else begin
      synth <= (synth & ~clrVec) | setVec;
      if (strobe.forceSet)                           respForce <= 1'b1;
      else if (statusWrite && statusWrData[RESP_BIT]) respForce <= 1'b0;
    end
  end

  assign mergedStatus = (hwStatus & ~holdVec) | synth;
  assign irq          = |(mergedStatus & enVec);
  assign hwClear      = statusWrite | strobe.deferClr;
  assign hwClearMask  = clrVec | (strobe.deferClr ? holdVec : '0);
endmodule

// File: rtl/busy_done_mon.sv
`timescale 1ns/1ps
module busy_done_mon
  import busy_done_pkg::*;
#(
  parameter int W          = 32,
  parameter int TICK_DIV   = 125000,
  parameter int TIMEOUT_MS = 250,
  parameter int RESP_BIT   = 0,
  parameter int DE_BIT     = 1,
  parameter int DTO_BIT    = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdIssue,
  input  logic         cmdHasData,
  input  logic [1:0]   cmdRespType,
  input  logic         xferAutoStop,
  input  logic         xferMulti,
  input  logic [W-1:0] hwStatus,
  input  logic [W-1:0] sigEnable,
  input  logic         lineActive,
  input  logic         dataInhibit,
  input  logic         statusWrite,
  input  logic [W-1:0] statusWrData,
  output logic [W-1:0] mergedStatus,
  output logic         irq,
  output logic         hwClear,
  output logic [W-1:0] hwClearMask
);
  ctrl_strobe_t strobe;
  logic         tick, timeoutHit;

  busy_done_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdIssue(cmdIssue), .cmdHasData(cmdHasData), .cmdRespType(cmdRespType),
    .xferAutoStop(xferAutoStop), .xferMulti(xferMulti),
    .hwRespBit(hwStatus[RESP_BIT]), .hwDeBit(hwStatus[DE_BIT]),
    .lineActive(lineActive), .dataInhibit(dataInhibit),
    .tick(tick), .timeoutHit(timeoutHit), .strobe(strobe)
  );

  busy_done_dp #(
    .W(W), .TICK_DIV(TICK_DIV), .TIMEOUT_MS(TIMEOUT_MS),
    .RESP_BIT(RESP_BIT), .DE_BIT(DE_BIT), .DTO_BIT(DTO_BIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hwStatus(hwStatus), .sigEnable(sigEnable),
    .statusWrite(statusWrite), .statusWrData(statusWrData),
    .tick(tick), .timeoutHit(timeoutHit),
    .mergedStatus(mergedStatus), .irq(irq),
    .hwClear(hwClear), .hwClearMask(hwClearMask)
  );
endmodule

// File: rtl/busy_done_chk.sv
`timescale 1ns/1ps
module busy_done_chk #(
  parameter int W        = 32,
  parameter int RESP_BIT = 0,
  parameter int DE_BIT   = 1
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] hwStatus,
  input logic [W-1:0] sigEnable,
  input logic         lineActive,
  input logic         dataInhibit,
  input logic         statusWrite,
  input logic [W-1:0] statusWrData,
  input logic [W-1:0] mergedStatus,
  input logic         irq,
  input logic         hwClear,
  input logic [W-1:0] hwClearMask
);
  localparam logic [W-1:0] TRIG_MASK = (W'(1) << RESP_BIT) | (W'(1) << DE_BIT);

  // R8: a host write reaches the hardware clear in the same cycle
  assert_write_passthrough_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusWrite |-> (hwClear && ((hwClearMask & statusWrData) == statusWrData)));

  // R3: a clear not caused by a write happens only when the line is busy
  assert_defer_needs_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hwClear && !statusWrite) |-> (lineActive || dataInhibit));

  // R5: a deferral clears exactly one trigger bit
  assert_defer_single_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hwClear && !statusWrite) |->
      (($countones(hwClearMask) == 1) && ((hwClearMask & ~TRIG_MASK) == '0)));

  // R8: raw bits other than the trigger bits always reach the host
  assert_merge_keeps_raw_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((hwStatus & ~TRIG_MASK & ~mergedStatus) == '0));

  // R10: with the response bit enabled, irq follows the enabled status
  assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    sigEnable[RESP_BIT] |-> (irq == (|(mergedStatus & sigEnable))));
endmodule

bind busy_done_mon busy_done_chk #(.W(W), .RESP_BIT(RESP_BIT), .DE_BIT(DE_BIT)) uChk (
  .clk(clk), .rstN(rstN), .hwStatus(hwStatus), .sigEnable(sigEnable),
  .lineActive(lineActive), .dataInhibit(dataInhibit),
  .statusWrite(statusWrite), .statusWrData(statusWrData),
  .mergedStatus(mergedStatus), .irq(irq),
  .hwClear(hwClear), .hwClearMask(hwClearMask)
);

// File: tb/sim_busy_done_mon.sv
`timescale 1ns/1ps
module sim_busy_done_mon;
  localparam int W = 32;
  localparam int DIV = 8;
  localparam int TMO = 6;
  localparam logic [W-1:0] RESP = 32'h1;
  localparam logic [W-1:0] DE   = 32'h2;
  localparam logic [W-1:0] DTO  = 32'h0010_0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdIssue = 0, cmdHasData = 0, xferAutoStop = 0, xferMulti = 0;
  logic [1:0] cmdRespType = 2'b00;
  logic [W-1:0] hwRaw = '0, sigEnable = '0, statusWrData = '0;
  logic lineActive = 0, dataInhibit = 0, statusWrite = 0;
  logic [W-1:0] mergedStatus, hwClearMask;
  logic irq, hwClear;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  busy_done_mon #(.W(W), .TICK_DIV(DIV), .TIMEOUT_MS(TMO)) u0 (
    .clk(clk), .rstN(rstN), .cmdIssue(cmdIssue), .cmdHasData(cmdHasData),
    .cmdRespType(cmdRespType), .xferAutoStop(xferAutoStop), .xferMulti(xferMulti),
    .hwStatus(hwRaw), .sigEnable(sigEnable), .lineActive(lineActive),
    .dataInhibit(dataInhibit), .statusWrite(statusWrite), .statusWrData(statusWrData),
    .mergedStatus(mergedStatus), .irq(irq), .hwClear(hwClear), .hwClearMask(hwClearMask)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic issue(input bit hasData, input logic [1:0] rt, input bit aStop, input bit multi);
    step();
    cmdIssue = 1; cmdHasData = hasData; cmdRespType = rt; xferAutoStop = aStop; xferMulti = multi;
    step();
    cmdIssue = 0; cmdHasData = 0; cmdRespType = 0; xferAutoStop = 0; xferMulti = 0;
  endtask

  task automatic hostClearAll();
    statusWrite = 1; statusWrData = '1;
    step();
    statusWrite = 0; statusWrData = '0; hwRaw = '0;
    step();
  endtask

  task automatic testReset();
    @(negedge clk);
    check(mergedStatus == '0, "R8 reset status", mergedStatus, '0);
    check({irq, hwClear} == 2'b00, "R8 reset strobes", {30'b0, irq, hwClear}, '0);
  endtask

  task automatic testNodataFree();
    sigEnable = '0;
    issue(0, 2'b11, 0, 0);
    hwRaw = RESP;
    @(negedge clk);
    check(mergedStatus[0] == 1'b0, "R4 trigger hidden", mergedStatus, '0);
    check(hwClear == 1'b0, "R4 no clear when free", {31'b0, hwClear}, '0);
    step();
    @(negedge clk);
    check((mergedStatus & (RESP | DE)) == (RESP | DE), "R1 R4 synth resp+de", mergedStatus, RESP | DE);
    check(irq == 1'b1, "R10 forced resp enable", {31'b0, irq}, 1);
    step();
    statusWrite = 1; statusWrData = RESP | DE;
    @(negedge clk);
    check(hwClear && hwClearMask == (RESP | DE), "R8 write passthrough", hwClearMask, RESP | DE);
    step();
    statusWrite = 0; statusWrData = '0; hwRaw = '0;
    @(negedge clk);
    check(mergedStatus == '0, "R8 write clears synth", mergedStatus, '0);
    step();
    hwRaw = RESP;
    @(negedge clk);
    check(mergedStatus[0] && !hwClear, "R9 disarmed after completion", mergedStatus, RESP);
    check(irq == 1'b0, "R10 force dropped after clear", {31'b0, irq}, 0);
    step();
    hwRaw = '0;
  endtask

  task automatic testNoArm();
    lineActive = 1;
    issue(0, 2'b10, 0, 0);
    hwRaw = RESP;
    @(negedge clk);
    check(mergedStatus == RESP && !hwClear, "R1 other response type not armed", mergedStatus, RESP);
    step(); hwRaw = '0;
    issue(1, 2'b11, 0, 1);
    hwRaw = DE;
    @(negedge clk);
    check(mergedStatus == DE && !hwClear, "R2 single transfer bit not armed", mergedStatus, DE);
    step(); hwRaw = '0; lineActive = 0;
    step();
  endtask

  task automatic testAc12Release();
    int first = -1;
    issue(1, 2'b10, 1, 1);
    lineActive = 1; hwRaw = DE;
    @(negedge clk);
    check(hwClear && hwClearMask == DE, "R2 R5 deferred clear of trigger", hwClearMask, DE);
    check(mergedStatus[1] == 1'b0, "R5 trigger hidden while busy", mergedStatus, '0);
    for (int i = 1; i <= 60; i++) begin
      step();
      if (i == 1) hwRaw = '0;
      if (i == 20) lineActive = 0;
      @(negedge clk);
      if (first < 0 && mergedStatus[1]) first = i;
    end
    check(first == 3 * DIV + 1, "R6 release seen at next tick", W'(first), W'(3 * DIV + 1));
    check(mergedStatus == DE, "R6 only transfer-complete in auto-stop", mergedStatus, DE);
    step();
    lineActive = 1; hwRaw = DE;
    @(negedge clk);
    check(mergedStatus[1] && !hwClear, "R9 disarmed after release", mergedStatus, DE);
    step();
    lineActive = 0;
    hostClearAll();
  endtask

  task automatic testNodataTimeout();
    int first = -1;
    issue(0, 2'b11, 0, 0);
    dataInhibit = 1; hwRaw = RESP;
    @(negedge clk);
    check(hwClear && hwClearMask == RESP, "R3 inhibit alone is busy", hwClearMask, RESP);
    for (int i = 1; i <= 70; i++) begin
      step();
      if (i == 1) hwRaw = '0;
      @(negedge clk);
      if (first < 0 && mergedStatus[20]) first = i;
    end
    check(first == TMO * DIV + 1, "R7 timeout cycle", W'(first), W'(TMO * DIV + 1));
    check(mergedStatus == DTO, "R7 timeout only", mergedStatus, DTO);
    sigEnable = DTO;
    #1;
    check(irq == 1'b1, "R10 irq from enabled timeout", {31'b0, irq}, 1);
    step();
    sigEnable = '0; dataInhibit = 0;
    hostClearAll();
    @(negedge clk);
    check(mergedStatus == '0, "R8 cleared after timeout", mergedStatus, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    testReset();
    testNodataFree();
    testNoArm();
    testAc12Release();
    testNodataTimeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule